// File: doc/BRIEF.md
# Daisy-Chain Safe SPI Control Slave

This block is a 16-bit full-duplex SPI slave for a multi-channel switch controller. While the chip select is low it shifts a control word in on SI and shifts a diagnosis word out on SO. The diagnosis word is assembled from per-channel open-load and fault flags. The received control word is handed to the rest of the chip only when the frame closes with a legal length. The serial pins are oversampled by the system clock, so SCLK is treated as data and never as a clock.

The frame-length rule makes the slave usable in daisy chains that mix 8-bit and 16-bit devices. A frame is accepted when the number of SCLK cycles is a nonzero multiple of eight and at least the word width. If a longer frame is accepted, the word kept is the last one shifted in. A sticky error flag is raised by reset and by any rejected frame. It is ORed onto SO from the chip-select fall until the first rising SCLK edge, so a downstream host sees the error even through other chain members. After its own word has been shifted out, the slave passes the received SI bits through, and so behaves as a 16-bit stage in the chain.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, ctrl_word is 16'hFFFF, ctrl_commit is 0, so_oe is 0 and the error flag is set.
- R2: While cs_n is high, so_oe is 0 and activity on sclk and si changes neither ctrl_word nor ctrl_commit.
- R3: From the fall of cs_n until the first rising sclk edge, so_oe is 1 and so equals the error flag ORed with the current si level.
- R4: The rising sclk edge numbered k (k = 1..16) puts diagnosis bit 16-k on so, so the MSB goes first. Diagnosis bit 2c+1 is chan_open[c] and bit 2c is chan_fault[c], so channel 7 occupies bits 15 and 14.
- R5: From the 17th rising sclk edge on, so repeats the si bits in the order they were received, delayed by 16 bit times.
- R6: si is sampled on falling sclk edges. When cs_n rises after N falling edges, where N is a nonzero multiple of 8 and N >= 16, ctrl_word takes the last 16 received bits, with the earliest of them as bit 15.
- R7: When cs_n rises after any other count of falling edges (0, 8, or a count that is not a multiple of 8), ctrl_word is unchanged and ctrl_commit stays low.
- R8: The error flag is cleared by an accepted frame and set by a rejected frame.
- R9: The length rule holds for frames far longer than one word, for example 72 edges accepted and 73 rejected.
- R10: An accepted frame raises ctrl_commit for exactly one system clock, in the same cycle that ctrl_word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |
| chan_open | input | CHANNELS | Per-channel open-load flags |
| chan_fault | input | CHANNELS | Per-channel fault flags |
| ctrl_word | output | 2*CHANNELS | Committed control word |
| ctrl_commit | output | 1 | One-cycle strobe when ctrl_word is updated |

## Verification
The bench sweeps every frame length from 0 to 40 SCLK cycles and adds 72, 73 and 120. This covers the short multiples 0 and 8, the non-multiples around 16 and 24, and lengths long enough to saturate the unit counter. A design that drops the minimum-length rule would accept 8-bit frames. A counter that wraps instead of saturating would misjudge long frames. Before each frame the bench checks the SO level with SI held low, which exposes an error flag that is not sticky or not cleared. Every shifted bit is compared, so an off-by-one at the shift boundary, a wrong channel interleave, or a missing pass-through of SI after bit 0 shows up at once.

// File: rtl/spi_fv_pkg.sv
package spi_fv_pkg;

   // Edge events derived from the oversampled serial pins.
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sclk_rise;
      logic sclk_fall;
   } spi_evt_t;

endpackage

// File: rtl/spi_fv_sync.sv
module spi_fv_sync #(
   parameter int STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 sclk,
   input  logic                 si,
   output logic                 cs_s,
   output logic                 si_s,
   output spi_fv_pkg::spi_evt_t evt
);
   logic [STAGES-1:0] cs_pipe, sclk_pipe, si_pipe;
   logic              cs_d, sclk_d;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_pipe   <= 1'b1;
               sclk_pipe <= 1'b0;
               si_pipe   <= 1'b0;
            end else begin
               cs_pipe   <= cs_n;
               sclk_pipe <= sclk;
               si_pipe   <= si;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_pipe   <= '1;
               sclk_pipe <= '0;
               si_pipe   <= '0;
            end else begin
               cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
               sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
               si_pipe   <= {si_pipe[STAGES-2:0], si};
            end
         end
      end
   endgenerate

   assign cs_s = cs_pipe[STAGES-1];
   assign si_s = si_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_pipe[STAGES-1];
      end
   end

   always_comb begin
      evt.cs_fall   = cs_d & ~cs_s;
      evt.cs_rise   = ~cs_d & cs_s;
      evt.sclk_rise = ~cs_s & ~sclk_d & sclk_pipe[STAGES-1];
      evt.sclk_fall = ~cs_s & sclk_d & ~sclk_pipe[STAGES-1];
   end

   // A select edge and a serial-clock edge never coincide as events while deselected
   assert_no_clk_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> !(evt.sclk_rise || evt.sclk_fall));

endmodule

// File: rtl/spi_fv_shift.sv
module spi_fv_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              si_s,
   input  logic              cs_fall,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              err,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] shreg,
   output logic              so,
   output logic              so_oe
);
   logic so_bit;
   logic pre_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         so_bit    <= 1'b0;
         pre_phase <= 1'b0;
      end else if (cs_fall) begin
         shreg     <= load_word;
         pre_phase <= 1'b1;
      end else begin
         if (sclk_fall) begin
            shreg <= {shreg[WORD_W-2:0], si_s};
         end
         if (sclk_rise) begin
            so_bit    <= shreg[WORD_W-1];
            pre_phase <= 1'b0;
         end
      end
   end

   assign so    = pre_phase ? (err | si_s) : so_bit;
   assign so_oe = ~cs_s;

   // R3: the error window ends at the first rising serial-clock edge
   assert_pre_phase_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && !cs_fall) |=> !pre_phase);

endmodule

// File: rtl/spi_fv_frame.sv
module spi_fv_frame #(
   parameter int WORD_W = 16,
   parameter int UNIT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_fall,
   input  logic cs_rise,
   input  logic sclk_fall,
   output logic accept,
   output logic err
);
   localparam int MIN_UNITS = WORD_W / UNIT_W;
   localparam int MOD_W     = (UNIT_W > 1) ? $clog2(UNIT_W) : 1;
   localparam int UCNT_W    = $clog2(MIN_UNITS + 1);
   localparam logic [MOD_W-1:0]  MOD_LAST = MOD_W'(UNIT_W - 1);
   localparam logic [UCNT_W-1:0] UNIT_SAT = UCNT_W'(MIN_UNITS);

   logic [MOD_W-1:0]  mod_cnt;
   logic [UCNT_W-1:0] unit_cnt;
   logic              len_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_cnt  <= '0;
         unit_cnt <= '0;
      end else if (cs_fall) begin
         mod_cnt  <= '0;
         unit_cnt <= '0;
      end else if (sclk_fall) begin
         if (mod_cnt == MOD_LAST) begin
            mod_cnt <= '0;
            if (unit_cnt < UNIT_SAT) unit_cnt <= unit_cnt + 1'b1;
         end else begin
            mod_cnt <= mod_cnt + 1'b1;
         end
      end
   end

   assign len_ok = (mod_cnt == '0) && (unit_cnt >= UNIT_SAT);
   assign accept = cs_rise & len_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b1;
      else if (cs_rise) err <= ~len_ok;
   end

   // R9: the unit counter never passes its saturation point
   assert_unit_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unit_cnt <= UNIT_SAT);

   // R8: a rejected close leaves the error flag set
   assert_err_after_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !accept) |=> err);

   // R8: an accepted close clears the error flag
   assert_err_clear_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !err);

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
   parameter int CHANNELS    = 8,
   parameter int UNIT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WORD_W      = 2 * CHANNELS,
   parameter logic [WORD_W-1:0] CTRL_DEFAULT = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                si,
   output logic                so,
   output logic                so_oe,
   input  logic [CHANNELS-1:0] chan_open,
   input  logic [CHANNELS-1:0] chan_fault,
   output logic [WORD_W-1:0]   ctrl_word,
   output logic                ctrl_commit
);
   generate
      if (WORD_W != 2 * CHANNELS) begin : g_bad_word
         $error("WORD_W must equal twice CHANNELS");
      end
      if (UNIT_W < 1 || (UNIT_W & (UNIT_W - 1)) != 0) begin : g_bad_unit
         $error("UNIT_W must be a power of two");
      end
      if (WORD_W % UNIT_W != 0) begin : g_bad_ratio
         $error("WORD_W must be a multiple of UNIT_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                 cs_s, si_s;
   spi_fv_pkg::spi_evt_t evt;
   logic [WORD_W-1:0]    diag_word;
   logic [WORD_W-1:0]    shreg;
   logic                 accept, err;

   // Interleave the per-channel flags: odd bits open-load, even bits fault.
   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_pack
         assign diag_word[2*c+1] = chan_open[c];
         assign diag_word[2*c]   = chan_fault[c];
      end
   endgenerate

   spi_fv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sclk  (sclk),
      .si    (si),
      .cs_s  (cs_s),
      .si_s  (si_s),
      .evt   (evt)
   );

   spi_fv_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .si_s      (si_s),
      .cs_fall   (evt.cs_fall),
      .sclk_rise (evt.sclk_rise),
      .sclk_fall (evt.sclk_fall),
      .err       (err),
      .load_word (diag_word),
      .shreg     (shreg),
      .so        (so),
      .so_oe     (so_oe)
   );

   spi_fv_frame #(.WORD_W(WORD_W), .UNIT_W(UNIT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_fall   (evt.cs_fall),
      .cs_rise   (evt.cs_rise),
      .sclk_fall (evt.sclk_fall),
      .accept    (accept),
      .err       (err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_word   <= CTRL_DEFAULT;
         ctrl_commit <= 1'b0;
      end else begin
         ctrl_commit <= accept;
         if (accept) ctrl_word <= shreg;
      end
   end

   // R7 / R2: the control word moves only together with the strobe
   assert_ctrl_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_commit |-> $stable(ctrl_word));

   // R10: the strobe lasts a single cycle
   assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_commit |=> !ctrl_commit);

   // R2: the output stays released while deselected
   assert_so_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && !evt.cs_rise) |-> !so_oe);

endmodule

// File: tb/spi_frame_slave_tb.sv
module spi_frame_slave_tb;
   localparam int CH = 8;
   localparam int W  = 2 * CH;
   localparam int H  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
   logic          so, so_oe;
   logic [CH-1:0] chan_open = '0, chan_fault = '0;
   logic [W-1:0]  ctrl_word;
   logic          ctrl_commit;

   int n_tests = 0, n_fail = 0;
   int commit_cnt = 0, commit_run = 0, commit_maxrun = 0;
   bit done = 0;
   bit err_model = 1;
   logic [W-1:0] ctrl_model = '1;
   logic [127:0] txv;

   always #10 clk = ~clk;

   spi_frame_slave u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
      .so(so), .so_oe(so_oe), .chan_open(chan_open), .chan_fault(chan_fault),
      .ctrl_word(ctrl_word), .ctrl_commit(ctrl_commit)
   );

   always @(posedge clk) begin
      if (ctrl_commit) begin
         commit_cnt <= commit_cnt + 1;
         commit_run <= commit_run + 1;
         if (commit_run + 1 > commit_maxrun) commit_maxrun <= commit_run + 1;
      end else begin
         commit_run <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [W-1:0] diag_of(input logic [CH-1:0] op, input logic [CH-1:0] ft);
      logic [W-1:0] d;
      for (int c = 0; c < CH; c++) begin
         d[2*c+1] = op[c];
         d[2*c]   = ft[c];
      end
      return d;
   endfunction

   task automatic run_frame(input int n);
      logic [W-1:0] dg;
      bit           valid;
      int           c0;
      chan_open  = CH'(n * 37 + 5);
      chan_fault = CH'(n * 91 + 13);
      dg = diag_of(chan_open, chan_fault);
      for (int k = 0; k < 128; k++) txv[k] = (((k * 5 + n * 3) % 7) < 3);
      c0 = commit_cnt;
      cs_n = 1'b0; si = 1'b0;
      wclk(2 * H);
      chk(so_oe === 1'b1, "R3 so_oe on select", 32'(so_oe), 32'd1);
      chk(so === err_model, "R8 error flag level on so", 32'(so), 32'(err_model));
      si = txv[0];
      wclk(2 * H);
      chk(so === (err_model | txv[0]), "R3 so = err | si", 32'(so), 32'(err_model | txv[0]));
      for (int k = 0; k < n; k++) begin
         logic eb;
         sclk = 1'b1;
         wclk(H);
         eb = (k + 1 <= W) ? dg[W - 1 - k] : txv[k - W];
         if (k + 1 <= W) chk(so === eb, "R4 diagnosis bit", 32'(so), 32'(eb));
         else            chk(so === eb, "R5 pass-through bit", 32'(so), 32'(eb));
         sclk = 1'b0;
         wclk(H);
         si = txv[k + 1];
         wclk(H);
      end
      cs_n = 1'b1;
      wclk(3 * H);
      valid = (n >= W) && (n % 8 == 0);
      if (valid) for (int b = 0; b < W; b++) ctrl_model[W - 1 - b] = txv[n - W + b];
      err_model = !valid;
      if (valid) begin
         chk(commit_cnt - c0 == 1, "R6 one commit", 32'(commit_cnt - c0), 32'd1);
         chk(ctrl_word === ctrl_model, (n > 40) ? "R9 long frame word" : "R6 committed word",
             32'(ctrl_word), 32'(ctrl_model));
      end else begin
         chk(commit_cnt == c0, (n > 40) ? "R9 long frame rejected" : "R7 no commit",
             32'(commit_cnt - c0), 32'd0);
         chk(ctrl_word === ctrl_model, "R7 word unchanged", 32'(ctrl_word), 32'(ctrl_model));
      end
      chk(so_oe === 1'b0, "R2 so released", 32'(so_oe), 32'd0);
      si = 1'b0;
   endtask

   initial begin
      wclk(5);
      rst_n = 1'b1;
      wclk(3);
      chk(ctrl_word === 16'hFFFF, "R1 reset word", 32'(ctrl_word), 32'hFFFF);
      chk(ctrl_commit === 1'b0, "R1 reset strobe", 32'(ctrl_commit), 32'd0);
      chk(so_oe === 1'b0, "R1 reset so_oe", 32'(so_oe), 32'd0);

      for (int t = 0; t < 20; t++) begin
         sclk = t[0]; si = t[1];
         wclk(H);
         chk(so_oe === 1'b0, "R2 idle so_oe", 32'(so_oe), 32'd0);
      end
      sclk = 1'b0; si = 1'b0;
      wclk(H);
      chk(commit_cnt == 0, "R2 idle no commit", 32'(commit_cnt), 32'd0);
      chk(ctrl_word === 16'hFFFF, "R2 idle word", 32'(ctrl_word), 32'hFFFF);

      for (int n = 0; n <= 40; n++) run_frame(n);
      run_frame(72);
      run_frame(73);
      run_frame(120);
      run_frame(9);

      chk(commit_maxrun == 1, "R10 strobe width", 32'(commit_maxrun), 32'd1);

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule